// File: doc/BRIEF.md
# Debug Breakpoint and Step Gate

This block decides, cycle by cycle, whether a small microcontroller core may execute. A debug host can let the core run every cycle, hold it in reset, stop it when the fetched program address or program word matches a programmed value, or release it for a fixed number of execution cycles. The result is a single processor-ready enable. The core's clock-enable strobe is that enable ORed with system reset, so the core still sees its reset.

There are two breakpoint comparators, one on the program address and one on the program word. Each can be enabled separately, and a match halts the core in the same cycle. A step run is launched by the rising edge of a start strobe. A launch loads a down-counter from the requested count, and the core is enabled once for each remaining step. A breakpoint or a system reset empties the counter. Run-free and forced-reset bits are loaded together by a control write. A breakpoint withdraws the run-free permission, so the core stays halted until the host writes the control bits again.

Top module: `dbg_step_gate`

## Requirements
- R1: When `bp_en[0]` is 1 and `pc_addr` equals `bp_addr`, `bp_hit` is 1 in the same cycle.
- R2: When `bp_en[1]` is 1 and `pc_data` equals `bp_data`, `bp_hit` is 1 in the same cycle.
- R3: A comparison whose enable bit is 0 never raises `bp_hit`, whatever its operands are.
- R4: While `bp_hit` is 1, `proc_rdy` is 0.
- R5: A rising edge of `step_go` (1 now, 0 in the previous cycle) loads `step_cnt` into the step counter at the next edge. `stepping` is 1 while the counter is nonzero. The counter drops by one at each edge where `proc_rdy` is 1, so a run of N gives exactly N ready cycles. Holding `step_go` high launches only one run.
- R6: A launch with `step_cnt` equal to 0 leaves `stepping` at 0 and gives no ready cycle.
- R7: A breakpoint or `rst` clears the step counter at the next edge. A breakpoint wins over a launch in the same cycle.
- R8: `ctl_wr` loads `ctl_run_free` and `ctl_force_rst` into the run-control state at the next edge. With run-free set, no force and no breakpoint, `proc_rdy` is 1 every cycle.
- R9: A breakpoint in a cycle without `ctl_wr` clears run-free at the next edge. `proc_rdy` then stays 0 after the match goes away, until `ctl_wr` sets run-free again.
- R10: While forced reset is set, `proc_rdy` is 0 and the step counter keeps its value.
- R11: `core_stb` equals `proc_rdy` OR `rst` in every cycle.
- R12: After reset, `proc_rdy`, `stepping` and `bp_hit` (with enables 0) are 0, and run-free and forced reset are both clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| pc_addr | input | 13 | Current program address |
| pc_data | input | 14 | Current program word |
| bp_addr | input | 13 | Address breakpoint compare value |
| bp_data | input | 14 | Program word breakpoint compare value |
| bp_en | input | 2 | Bit 0 enables the address compare, bit 1 enables the word compare |
| step_cnt | input | 6 | Requested number of steps |
| step_go | input | 1 | Step start; a rising edge launches one run |
| ctl_wr | input | 1 | Loads the run-control bits |
| ctl_run_free | input | 1 | Run-free value to load |
| ctl_force_rst | input | 1 | Forced-reset value to load |
| proc_rdy | output | 1 | Core may execute this cycle |
| core_stb | output | 1 | Core clock enable: `proc_rdy` OR `rst` |
| stepping | output | 1 | Step counter is nonzero |
| bp_hit | output | 1 | An enabled comparison matches |

## Verification
A step launch and a breakpoint can land in the same cycle, and so can a breakpoint and a control write that sets run-free. The bench brings these together by letting random program addresses hit the compare value about a quarter of the time, while strobes and control writes fire at random. A directed case also puts a launch exactly on a matching address. A bench model judges the result: the breakpoint must empty the counter ahead of the launch, and the control write must win over the withdrawal of run-free.

// File: rtl/dbg_step_pkg.sv
package dbg_step_pkg;

  // Comparator: match only when the enable is set.
  function automatic logic gated_eq(input logic en, input logic [31:0] a, input logic [31:0] b);
    return en && (a == b);
  endfunction

  // Step counter next value, breakpoint first, then launch, then decrement.
  function automatic logic [5:0] cnt_next(input logic bp, input logic launch,
                                          input logic [5:0] load, input logic [5:0] cur,
                                          input logic rdy);
    if (bp)                      return '0;
    else if (launch)             return load;
    else if (rdy && cur != '0)   return cur - 6'd1;
    else                         return cur;
  endfunction

endpackage

// File: rtl/dbg_bp_match.sv
module dbg_bp_match #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 14
) (
  input  logic [ADDR_W-1:0] pc_addr,
  input  logic [DATA_W-1:0] pc_data,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [DATA_W-1:0] bp_data,
  input  logic [1:0]        bp_en,
  output logic              hit_addr,
  output logic              hit_data,
  output logic              hit
);
  import dbg_step_pkg::*;

  always_comb begin
    hit_addr = gated_eq(bp_en[0], 32'(pc_addr), 32'(bp_addr));
    hit_data = gated_eq(bp_en[1], 32'(pc_data), 32'(bp_data));
    hit      = hit_addr | hit_data;
  end
endmodule

// File: rtl/dbg_run_ctl.sv
module dbg_run_ctl (
  input  logic clk,
  input  logic rst,
  input  logic ctl_wr,
  input  logic ctl_run_free,
  input  logic ctl_force_rst,
  input  logic bp_hit,
  output logic run_free_q,
  output logic force_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run_free_q <= 1'b0;
      force_q    <= 1'b0;
    end else if (ctl_wr) begin
      run_free_q <= ctl_run_free;
      force_q    <= ctl_force_rst;
    end else if (bp_hit) begin
      run_free_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_step_cnt.sv
module dbg_step_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_go,
  input  logic [CNT_W-1:0] step_cnt,
  input  logic             bp_hit,
  input  logic             proc_rdy,
  output logic [CNT_W-1:0] cnt_q,
  output logic             launch,
  output logic             stepping
);
  import dbg_step_pkg::*;

  logic go_q;

  assign launch   = step_go && !go_q;
  assign stepping = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      go_q  <= step_go;
      cnt_q <= CNT_W'(cnt_next(bp_hit, launch, 6'(step_cnt), 6'(cnt_q), proc_rdy));
    end
  end
endmodule

// File: rtl/dbg_step_gate.sv
module dbg_step_gate #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 14,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc_addr,
  input  logic [DATA_W-1:0] pc_data,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [DATA_W-1:0] bp_data,
  input  logic [1:0]        bp_en,
  input  logic [CNT_W-1:0]  step_cnt,
  input  logic              step_go,
  input  logic              ctl_wr,
  input  logic              ctl_run_free,
  input  logic              ctl_force_rst,
  output logic              proc_rdy,
  output logic              core_stb,
  output logic              stepping,
  output logic              bp_hit
);
  logic             hit_addr, hit_data;
  logic             run_free_q, force_q;
  logic [CNT_W-1:0] cnt_q;
  logic             launch;

  dbg_bp_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .pc_addr(pc_addr), .pc_data(pc_data), .bp_addr(bp_addr), .bp_data(bp_data),
    .bp_en(bp_en), .hit_addr(hit_addr), .hit_data(hit_data), .hit(bp_hit)
  );

  dbg_run_ctl u_ctl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_run_free(ctl_run_free),
    .ctl_force_rst(ctl_force_rst), .bp_hit(bp_hit),
    .run_free_q(run_free_q), .force_q(force_q)
  );

  dbg_step_cnt #(.CNT_W(CNT_W)) u_step (
    .clk(clk), .rst(rst), .step_go(step_go), .step_cnt(step_cnt), .bp_hit(bp_hit),
    .proc_rdy(proc_rdy), .cnt_q(cnt_q), .launch(launch), .stepping(stepping)
  );

  assign proc_rdy = !force_q && !bp_hit && (run_free_q || stepping);
  assign core_stb = proc_rdy || rst;
endmodule

// File: rtl/dbg_step_gate_chk.sv
module dbg_step_gate_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             bp_hit,
  input logic             proc_rdy,
  input logic             stepping,
  input logic             core_stb,
  input logic             force_q,
  input logic             run_free_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             launch,
  input logic             ctl_wr
);
  p_bp_halts_r4: assert property (@(posedge clk) disable iff (rst)
    bp_hit |-> !proc_rdy);

  p_step_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && proc_rdy && !launch && !bp_hit) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_single_launch_r5: assert property (@(posedge clk) disable iff (rst)
    launch |=> !launch);

  p_bp_clears_step_r7: assert property (@(posedge clk) disable iff (rst)
    bp_hit |=> !stepping);

  p_bp_drops_runfree_r9: assert property (@(posedge clk) disable iff (rst)
    (bp_hit && !ctl_wr) |=> !run_free_q);

  p_force_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    force_q |-> !proc_rdy);

  p_force_holds_cnt_r10: assert property (@(posedge clk) disable iff (rst)
    (force_q && !bp_hit && !launch) |=> $stable(cnt_q));

  p_rst_strobe_r11: assert property (@(posedge clk)
    rst |-> core_stb);
endmodule

bind dbg_step_gate dbg_step_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bp_hit(bp_hit), .proc_rdy(proc_rdy), .stepping(stepping),
  .core_stb(core_stb), .force_q(force_q), .run_free_q(run_free_q), .cnt_q(cnt_q),
  .launch(launch), .ctl_wr(ctl_wr)
);

// File: tb/dbg_step_gate_bench.sv
module dbg_step_gate_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [12:0] pc_addr, bp_addr;
  logic [13:0] pc_data, bp_data;
  logic [1:0]  bp_en;
  logic [5:0]  step_cnt;
  logic        step_go, ctl_wr, ctl_run_free, ctl_force_rst;
  logic        proc_rdy, core_stb, stepping, bp_hit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  int m_cnt = 0;
  bit m_rf = 0, m_force = 0, m_goprev = 0;

  always #5 clk = ~clk;

  dbg_step_gate u_dbg_step_gate (
    .clk(clk), .rst(rst), .pc_addr(pc_addr), .pc_data(pc_data), .bp_addr(bp_addr),
    .bp_data(bp_data), .bp_en(bp_en), .step_cnt(step_cnt), .step_go(step_go),
    .ctl_wr(ctl_wr), .ctl_run_free(ctl_run_free), .ctl_force_rst(ctl_force_rst),
    .proc_rdy(proc_rdy), .core_stb(core_stb), .stepping(stepping), .bp_hit(bp_hit)
  );

  function automatic bit exp_hit();
    bit a = bp_en[0] && (pc_addr == bp_addr);
    bit d = bp_en[1] && (pc_data == bp_data);
    return a || d;
  endfunction

  function automatic bit exp_rdy();
    if (m_force) return 0;
    if (exp_hit()) return 0;
    return m_rf || (m_cnt > 0);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare outputs with model, then advance the model one edge
  task automatic step();
    bit h, r, l;
    #2;
    h = exp_hit();
    r = exp_rdy();
    if (bp_en[0] && pc_addr == bp_addr)      chk("R1 bp_hit", bp_hit, h);
    else if (bp_en[1] && pc_data == bp_data) chk("R2 bp_hit", bp_hit, h);
    else                                     chk("R3 bp_hit", bp_hit, h);
    if (m_force)   chk("R10 proc_rdy", proc_rdy, r);
    else if (h)    chk("R4 proc_rdy", proc_rdy, r);
    else if (m_rf) chk("R8 proc_rdy", proc_rdy, r);
    else           chk("R5 proc_rdy", proc_rdy, r);
    chk("R5 stepping", stepping, m_cnt > 0);
    chk("R11 core_stb", core_stb, r || rst);
    l = step_go && !m_goprev;
    if (rst) begin
      m_cnt = 0; m_rf = 0; m_force = 0; m_goprev = 0;
    end else begin
      m_goprev = step_go;
      if (h) m_cnt = 0;
      else if (l) m_cnt = int'(step_cnt);
      else if (r && m_cnt > 0) m_cnt = m_cnt - 1;
      if (ctl_wr) begin m_rf = ctl_run_free; m_force = ctl_force_rst; end
      else if (h) m_rf = 0;
    end
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 0;
  endtask

  task automatic idle_inputs();
    rst = 0; step_go = 0; ctl_wr = 0; ctl_run_free = 0; ctl_force_rst = 0;
    bp_en = 2'b00; step_cnt = 0;
  endtask

  int n_rdy;

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    rst = 1; pc_addr = 13'h0100; pc_data = 14'h0200;
    bp_addr = 13'h0155; bp_data = 14'h1abc;
    @(negedge clk);
    step(); step();
    rst = 0;
    // R12 reset state
    #1;
    chk("R12 proc_rdy", proc_rdy, 0);
    chk("R12 stepping", stepping, 0);
    chk("R12 bp_hit", bp_hit, 0);
    step();

    // R5: launch of 5 steps, go held high for several cycles
    step_cnt = 6'd5; step_go = 1;
    n_rdy = 0;
    for (int i = 0; i < 12; i++) begin
      #1; if (proc_rdy) n_rdy++;
      step();
      if (i == 6) step_go = 0;
    end
    chk("R5 ready count", n_rdy, 5);

    // R6: zero-length launch
    step_cnt = 0; step_go = 1; step(); step_go = 0;
    step(); #1; chk("R6 stepping", stepping, 0); chk("R6 proc_rdy", proc_rdy, 0);
    step();

    // R7: launch lands on a matching address
    bp_en = 2'b01; pc_addr = bp_addr; step_cnt = 6'd9; step_go = 1; step();
    step_go = 0; pc_addr = 13'h0001;
    #1; chk("R7 stepping", stepping, 0);
    step();

    // R8/R9: run free, then a breakpoint withdraws it
    ctl_wr = 1; ctl_run_free = 1; ctl_force_rst = 0; step();
    for (int i = 0; i < 3; i++) step();
    bp_en = 2'b10; pc_data = bp_data; step();
    pc_data = 14'h0003;
    #1; chk("R9 proc_rdy", proc_rdy, 0);
    step(); step();
    ctl_wr = 1; ctl_run_free = 1; step();
    #1; chk("R8 proc_rdy", proc_rdy, 1);
    step();

    // R10: force holds counter
    ctl_wr = 1; ctl_run_free = 0; ctl_force_rst = 1; step();
    step_cnt = 6'd3; step_go = 1; step(); step_go = 0;
    for (int i = 0; i < 4; i++) step();
    #1; chk("R10 stepping held", stepping, 1);
    ctl_wr = 1; ctl_force_rst = 0; step();
    for (int i = 0; i < 5; i++) step();

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      pc_addr  = ($urandom % 4 == 0) ? bp_addr : 13'($urandom);
      pc_data  = ($urandom % 5 == 0) ? bp_data : 14'($urandom);
      bp_en    = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      step_go  = ($urandom % 6 == 0);
      step_cnt = 6'($urandom % 12);
      ctl_wr   = ($urandom % 16 == 0);
      ctl_run_free  = $urandom % 2;
      ctl_force_rst = ($urandom % 4 == 0);
      rst      = ($urandom % 200 == 0);
      step();
    end
    idle_inputs();
    step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule